// File: doc/BRIEF.md
# Saturating Sigmoid Lookup Table

This block gives an approximation of the logistic function 1/(1+e^-x) for a 16-bit signed fixed-point operand with 10 fraction bits (real value = code / 1024). It returns the result in the same format. The result is not computed. The operand is first limited to the window [-8.0, +7.9375]. It is then cut down to a grid of 1/16 steps, and that grid point selects one entry of a 256-entry table. The table is generated at elaboration time from the logistic formula and rounded to the nearest output code.

A neural-network datapath uses the block as the activation stage that follows an accumulator. One operand is offered per cycle with a valid flag. The result appears one clock later with a matching valid flag. Between valid operands the output data keeps its last value.

Top module: `sig_lut_q510`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next output state is `out_valid` = 0 and `out_data` = 0.
- R2: `out_valid` after a rising edge equals the `in_valid` presented at that edge (one cycle of latency).
- R3: For an operand code x in [-8192, 8128], the step index is q = floor(x / 64), which is bits [13:6] of x read as two's complement. `out_data` = round(1024 / (1 + e^(-q/16))) with ties rounded up, and it appears one cycle after `in_valid` = 1.
- R4: Any operand code above 8128 gives the same result as 8128, which is 1024.
- R5: Any operand code below -8192 gives the same result as -8192, which is 0.
- R6: An operand of 0 gives 512 (0.5).
- R7: When `in_valid` is 0 at an edge, `out_data` keeps its previous value, whatever `in_data` carries.
- R8: Every result lies in 0..1024, and results do not decrease as the operand increases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand qualifier |
| in_data | input | 16 | Signed operand, 10 fraction bits |
| out_valid | output | 1 | Result qualifier, in_valid delayed one cycle |
| out_data | output | 16 | Result code, 10 fraction bits |

## Verification
Saturation and output hold can both act in the same cycle. This happens when an out-of-range code sits on `in_data` while `in_valid` is low. The bench drives the most extreme codes in both directions with the qualifier low and checks that `out_data` still shows the previous result and that `out_valid` is 0. It also sends valid operands back to back that swing between the two saturated ends, and checks that each result lands exactly one cycle later with no carry-over from its neighbour.

// File: rtl/sig_lut_pkg.sv
package sig_lut_pkg;

    localparam int SIG_DATA_W = 16;  // operand/result width
    localparam int SIG_FRAC_W = 10;  // fraction bits
    localparam int SIG_INT_W  = 3;   // magnitude bits of the covered window
    localparam int SIG_STEP_W = 4;   // fraction bits kept for indexing

    // Logistic value at grid point i / 2**step_w, as a rounded code scaled by 2**frac_w
    function automatic int sig_point(int i, int frac_w, int step_w);
        real x;
        real y;
        x = real'(i) / real'(1 << step_w);
        y = real'(1 << frac_w) / (1.0 + $exp(-x));
        return $rtoi(y + 0.5);
    endfunction

endpackage

// File: rtl/sig_clamp.sv
module sig_clamp #(
    parameter int DATA_W = sig_lut_pkg::SIG_DATA_W,
    parameter int FRAC_W = sig_lut_pkg::SIG_FRAC_W,
    parameter int INT_W  = sig_lut_pkg::SIG_INT_W,
    parameter int STEP_W = sig_lut_pkg::SIG_STEP_W,
    localparam int IDX_W = 1 + INT_W + STEP_W
) (
    input  logic signed [DATA_W-1:0] x,
    output logic        [IDX_W-1:0]  idx
);
    localparam int LSB  = FRAC_W - STEP_W;
    localparam int LO_I = -(1 << (INT_W + FRAC_W));
    localparam int HI_I = (1 << (INT_W + FRAC_W)) - (1 << LSB);
    localparam logic signed [DATA_W-1:0] LO = DATA_W'(LO_I);
    localparam logic signed [DATA_W-1:0] HI = DATA_W'(HI_I);
    localparam logic [IDX_W-1:0] IDX_TOP = {1'b0, {(IDX_W-1){1'b1}}};
    localparam logic [IDX_W-1:0] IDX_BOT = {1'b1, {(IDX_W-1){1'b0}}};

    logic signed [DATA_W-1:0] lim;

    always_comb begin
        if (x > HI)
            lim = HI;
        else if (x < LO)
            lim = LO;
        else
            lim = x;
        idx = IDX_W'(lim >>> LSB);
    end

    always_comb begin
        if (x >= HI)
            AST_CLAMP_HIGH: assert (idx == IDX_TOP); // R4
        if (x <= LO)
            AST_CLAMP_LOW: assert (idx == IDX_BOT); // R5
    end

endmodule

// File: rtl/sig_rom.sv
module sig_rom #(
    parameter int DATA_W = sig_lut_pkg::SIG_DATA_W,
    parameter int FRAC_W = sig_lut_pkg::SIG_FRAC_W,
    parameter int INT_W  = sig_lut_pkg::SIG_INT_W,
    parameter int STEP_W = sig_lut_pkg::SIG_STEP_W,
    localparam int IDX_W = 1 + INT_W + STEP_W
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] val
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] entry [DEPTH];

    for (genvar j = 0; j < DEPTH; j++) begin : g_entry
        localparam int SI = (j >= DEPTH / 2) ? j - DEPTH : j;
        assign entry[j] = DATA_W'(sig_lut_pkg::sig_point(SI, FRAC_W, STEP_W));
    end

    assign val = entry[idx];

endmodule

// File: rtl/sig_out_stage.sv
module sig_out_stage #(
    parameter int DATA_W = sig_lut_pkg::SIG_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              d_valid,
    input  logic [DATA_W-1:0] d,
    output logic              q_valid,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid <= 1'b0;
            q       <= '0;
        end else begin
            q_valid <= d_valid;
            if (d_valid)
                q <= d;
        end
    end

    AST_VALID_SET: assert property (@(posedge clk) disable iff (rst)
        d_valid |=> q_valid); // R2
    AST_VALID_CLR: assert property (@(posedge clk) disable iff (rst)
        !d_valid |=> !q_valid); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !d_valid |=> $stable(q)); // R7

endmodule

// File: rtl/sig_lut_q510.sv
module sig_lut_q510 #(
    parameter int DATA_W = sig_lut_pkg::SIG_DATA_W,
    parameter int FRAC_W = sig_lut_pkg::SIG_FRAC_W,
    parameter int INT_W  = sig_lut_pkg::SIG_INT_W,
    parameter int STEP_W = sig_lut_pkg::SIG_STEP_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_data,
    output logic                     out_valid,
    output logic        [DATA_W-1:0] out_data
);
    localparam int IDX_W = 1 + INT_W + STEP_W;
    localparam logic [DATA_W-1:0] ONE  = DATA_W'(1 << FRAC_W);
    localparam logic [DATA_W-1:0] HALF = DATA_W'(1 << (FRAC_W - 1));

    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] lut_val;

    sig_clamp #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .INT_W(INT_W), .STEP_W(STEP_W)) u_clamp (
        .x   (in_data),
        .idx (idx)
    );

    sig_rom #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .INT_W(INT_W), .STEP_W(STEP_W)) u_rom (
        .idx (idx),
        .val (lut_val)
    );

    sig_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk     (clk),
        .rst     (rst),
        .d_valid (in_valid),
        .d       (lut_val),
        .q_valid (out_valid),
        .q       (out_data)
    );

    AST_ZERO_HALF: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_data == '0) |=> out_data == HALF); // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_data <= ONE); // R8

endmodule

// File: tb/tb_sig_lut_q510.sv
module tb_sig_lut_q510;

    logic               clk = 1'b0;
    logic               rst;
    logic               in_valid;
    logic signed [15:0] in_data;
    logic               out_valid;
    logic        [15:0] out_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk; // 250 MHz

    sig_lut_q510 dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    function automatic int ref_sig(int x);
        int c;
        int q;
        real y;
        c = x;
        if (c > 8128) c = 8128;
        if (c < -8192) c = -8192;
        q = c >>> 6;
        y = 1024.0 / (1.0 + $exp(-real'(q) / 16.0));
        return $rtoi(y + 0.5);
    endfunction

    task automatic check(string req, int actual, int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    // drive one cycle, sample just after the capturing edge
    task automatic step(bit v, int x);
        @(negedge clk);
        in_valid = v;
        in_data  = 16'(x);
        @(posedge clk);
        #1;
    endtask

    task automatic apply_check(string req, int x);
        step(1'b1, x);
        check({req, " valid"}, int'(out_valid), 1);
        check(req, int'(out_data), ref_sig(x));
    endtask

    initial begin
        #400000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        int prev;
        int held;
        seed = $urandom(32'h5a17);
        rst = 1'b1;
        in_valid = 1'b1;
        in_data = 16'sd4000;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset valid", int'(out_valid), 0);
        check("R1 reset data", int'(out_data), 0);
        @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b0;

        // directed points
        apply_check("R6 zero", 0);
        check("R6 zero is half", int'(out_data), 512);
        apply_check("R3 minus one lsb", -1);
        apply_check("R3 plus one step", 64);
        apply_check("R3 mid positive", 3000);
        apply_check("R3 mid negative", -3000);
        apply_check("R4 upper edge", 8128);
        check("R4 upper edge 1024", int'(out_data), 1024);
        apply_check("R4 just above", 8129);
        check("R4 just above 1024", int'(out_data), 1024);
        apply_check("R4 max code", 32767);
        check("R4 max code 1024", int'(out_data), 1024);
        apply_check("R5 lower edge", -8192);
        check("R5 lower edge 0", int'(out_data), 0);
        apply_check("R5 just below", -8193);
        check("R5 just below 0", int'(out_data), 0);
        apply_check("R5 min code", -32768);
        check("R5 min code 0", int'(out_data), 0);

        // back-to-back swings between saturated ends
        for (int k = 0; k < 6; k++) begin
            apply_check("R2 swing", (k % 2 == 0) ? 30000 : -30000);
            check("R2 swing end", int'(out_data), (k % 2 == 0) ? 1024 : 0);
        end

        // hold while idle, with extreme codes on the data pins
        apply_check("R7 setup", 1500);
        held = ref_sig(1500);
        step(1'b0, 32767);
        check("R2 idle valid", int'(out_valid), 0);
        check("R7 hold vs high code", int'(out_data), held);
        step(1'b0, -32768);
        check("R7 hold vs low code", int'(out_data), held);
        step(1'b0, 0);
        check("R7 hold vs zero", int'(out_data), held);
        apply_check("R2 resume", -700);

        // sweep every grid point: range and monotonicity
        prev = -1;
        for (int x = -8192; x <= 8128; x += 64) begin
            step(1'b1, x);
            checks++;
            if (int'(out_data) > 1024 || int'(out_data) < prev) begin
                errors++;
                $display("FAIL R8 at %0d: actual %0d expected >= %0d and <= 1024",
                         x, out_data, prev);
            end
            check("R3 sweep", int'(out_data), ref_sig(x));
            prev = int'(out_data);
        end

        // random mix of qualified and idle cycles over the whole code space
        held = int'(out_data);
        for (int k = 0; k < 3000; k++) begin
            bit v;
            int x;
            v = ($urandom % 4) != 0;
            x = ($urandom % 2 == 0) ? int'($signed(16'($urandom)))
                                     : int'($urandom % 16384) - 8192;
            step(v, x);
            check("R2 random valid", int'(out_valid), int'(v));
            if (v) held = ref_sig(x);
            check(v ? "R3 random data" : "R7 random hold", int'(out_data), held);
        end

        // reset in mid-stream
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b1;
        @(posedge clk);
        #1;
        check("R1 mid reset valid", int'(out_valid), 0);
        check("R1 mid reset data", int'(out_data), 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule